// File: doc/BRIEF.md
# Oscillator Capacitor-Bank Calibration Controller

This block picks a 9-bit capacitor-bank code for a local oscillator so that the loop control voltage of the surrounding PLL settles inside its valid window. A start request launches a successive-approximation search over the code. Each search step applies a trial code, waits a programmable settling time, then samples a 2-bit level indicator. The indicator tells whether the control voltage is below the window, inside it or above it.

Two optional passes follow the search. A correction pass steps the code one count at a time toward the window, with a limit of eight moves. A fine-adjust pass does the same with a limit of two moves. A final settling wait closes the run, and the level is judged once more at its end. Two error flags report the outcome: one for a level still outside the window, one for a stepping pass that gave up or ran into the end of the code range. A select input can replace the calibrated code with a code supplied from outside.

Time is counted in units of `UNIT` clock cycles, and one unit stands for 10 µs of settling time.

Top module: `capbank_cal`

## Requirements
- R1: After reset, `busy`, `errLevel` and `errSearch` are 0, and `codeOut` is 0 when `manualSel` is 0.
- R2: A `start` pulse while idle raises `busy` on the next clock edge. `busy` stays high until the final wait ends. A `start` while `busy` is high is ignored and does not lengthen the run.
- R3: The search tests code bits from bit 8 down to bit 0, setting each as a trial. `level` is encoded as 0 = below window, 1 = inside window, 3 = above window, and 2 is treated as above window. A trial bit is kept when the level is 0 or 1 and cleared when it is 2 or 3.
- R4: Each search step lasts `UNIT << sarSel` cycles, so raising `sarSel` from 0 to 1 lengthens a run by 9·UNIT cycles.
- R5: With `corrEn` = 1, a correction pass follows the search. Each of its steps lasts `20·UNIT << corrSel` cycles. At the end of each step the pass stops if the level is 1. Otherwise it adds 1 to the code when the level is 0 and subtracts 1 when the level is 2 or 3. After 8 moves without reaching level 1, the pass stops and sets `errSearch`.
- R6: With `fineEn` = 1, a fine-adjust pass follows (after the correction pass when that is enabled). It uses the same step time and direction rule but at most 2 moves. Reaching that limit does not set `errSearch`.
- R7: If either pass needs to step above 511 or below 0, it stops at once, leaves the code unchanged and sets `errSearch`.
- R8: The run ends with a wait of `20·UNIT << waitSel` cycles. `errLevel` is then set if `level` is not 1, on the same edge where `busy` falls.
- R9: An accepted `start` clears both error flags. They then hold their values while the block is idle.
- R10: With `manualSel` = 1, `codeOut` equals `manualCode`. With `manualSel` = 0, it shows the calibrated code, which stays unchanged while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Calibration request pulse |
| sarSel | input | 2 | Search step time select |
| corrSel | input | 2 | Correction and fine-adjust step time select |
| waitSel | input | 2 | Final wait time select |
| corrEn | input | 1 | Correction pass enable |
| fineEn | input | 1 | Fine-adjust pass enable |
| level | input | 2 | Control-voltage region indicator |
| manualSel | input | 1 | 1 selects the manual code |
| manualCode | input | 9 | Code supplied from outside |
| codeOut | output | 9 | Applied capacitor-bank code |
| busy | output | 1 | Calibration in progress |
| errLevel | output | 1 | Final level outside the window |
| errSearch | output | 1 | A stepping pass gave up or hit a range end |

## Verification
A wrong keep or clear decision during the search is visible at the very end of a run. It appears as a final code that differs from a bench model, which replays the search and the passes against the same level function. A timer loaded with the wrong period changes the length of `busy` by a fixed number of cycles. Runs that differ in a single select field show this as a wrong duration difference as soon as `busy` falls. A bad move counter or range check shows up in the same run as a wrong `errSearch` or a wrong final code. A level shift applied between the search and the passes shows whether the passes actually step the code.

// File: rtl/cbcal_pkg.sv
package cbcal_pkg;
  typedef enum logic [1:0] {PER_SAR, PER_CORR, PER_WAIT} perSel_e;

  typedef struct packed {
    logic    init;
    logic    trial;
    logic    decide;
    logic    stepUp;
    logic    stepDown;
    logic    clrMoves;
    logic    setErr1;
    logic    setErr2;
    logic    load;
    perSel_e per;
  } strobes_t;
endpackage

// File: rtl/cbcal_datapath.sv
module cbcal_datapath
  import cbcal_pkg::*;
#(
  parameter int UNIT   = 4,
  parameter int CODE_W = 9,
  parameter int MOVE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [1:0]        level,
  input  logic [1:0]        sarSel,
  input  logic [1:0]        corrSel,
  input  logic [1:0]        waitSel,
  output logic [CODE_W-1:0] calCode,
  output logic [MOVE_W-1:0] moves,
  output logic              timerDone,
  output logic              bitZero,
  output logic              atMax,
  output logic              atMin,
  output logic              err1,
  output logic              err2
);
  localparam int MAXPER = UNIT * 160;
  localparam int TW     = $clog2(MAXPER + 1);
  localparam int IW     = $clog2(CODE_W);

  logic [TW-1:0] timer;
  logic [TW-1:0] period;
  logic [IW-1:0] bitIdx;

  always_comb begin
    case (strb.per)
      PER_SAR:  period = TW'(UNIT) << sarSel;
      PER_CORR: period = TW'(UNIT * 20) << corrSel;
      default:  period = TW'(UNIT * 20) << waitSel;
    endcase
  end

  assign timerDone = (timer == '0);
  assign bitZero   = (bitIdx == '0);
  assign atMax     = &calCode;
  assign atMin     = (calCode == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            timer <= '0;
    else if (strb.load)   timer <= period - TW'(1);
    else if (timer != '0) timer <= timer - TW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calCode <= '0;
      bitIdx  <= '0;
      moves   <= '0;
      err1    <= 1'b0;
      err2    <= 1'b0;
    end else begin
      if (strb.init) begin
        calCode <= '0;
        bitIdx  <= IW'(CODE_W - 1);
        moves   <= '0;
        err1    <= 1'b0;
        err2    <= 1'b0;
      end
      if (strb.trial) calCode[bitIdx] <= 1'b1;
      if (strb.decide) begin
        if (level[1]) calCode[bitIdx] <= 1'b0;
        if (bitIdx != '0) bitIdx <= bitIdx - IW'(1);
      end
      if (strb.stepUp) begin
        calCode <= calCode + CODE_W'(1);
        moves   <= moves + MOVE_W'(1);
      end
      if (strb.stepDown) begin
        calCode <= calCode - CODE_W'(1);
        moves   <= moves + MOVE_W'(1);
      end
      if (strb.clrMoves) moves <= '0;
      if (strb.setErr1)  err1 <= 1'b1;
      if (strb.setErr2)  err2 <= 1'b1;
    end
  end
endmodule

// File: rtl/cbcal_ctrl.sv
module cbcal_ctrl
  import cbcal_pkg::*;
#(
  parameter int CORR_LIMIT = 8,
  parameter int FINE_LIMIT = 2,
  parameter int MOVE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              corrEn,
  input  logic              fineEn,
  input  logic [1:0]        level,
  input  logic              timerDone,
  input  logic              bitZero,
  input  logic              atMax,
  input  logic              atMin,
  input  logic [MOVE_W-1:0] moves,
  output strobes_t          strb,
  output logic              busy
);
  typedef enum logic [2:0] {S_IDLE, S_TRIAL, S_SAR, S_CORR, S_FINE, S_PLL} state_e;

  state_e state, nextState;
  logic   inCorr, leave;
  logic [MOVE_W-1:0] limit;

  assign busy   = (state != S_IDLE);
  assign inCorr = (state == S_CORR);
  assign limit  = inCorr ? MOVE_W'(CORR_LIMIT) : MOVE_W'(FINE_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = strobes_t'('0);
    nextState = state;
    leave     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strb.init = 1'b1;
        nextState = S_TRIAL;
      end
      S_TRIAL: begin
        strb.trial = 1'b1;
        strb.load  = 1'b1;
        strb.per   = PER_SAR;
        nextState  = S_SAR;
      end
      S_SAR: if (timerDone) begin
        strb.decide = 1'b1;
        if (!bitZero) nextState = S_TRIAL;
        else if (corrEn || fineEn) begin
          strb.clrMoves = 1'b1;
          strb.load     = 1'b1;
          strb.per      = PER_CORR;
          nextState     = corrEn ? S_CORR : S_FINE;
        end else begin
          strb.load = 1'b1;
          strb.per  = PER_WAIT;
          nextState = S_PLL;
        end
      end
      S_CORR, S_FINE: if (timerDone) begin
        if (level == 2'd1) leave = 1'b1;
        else if (moves == limit) begin
          leave        = 1'b1;
          strb.setErr2 = inCorr;
        end else if (level == 2'd0) begin
          if (atMax) begin
            leave        = 1'b1;
            strb.setErr2 = 1'b1;
          end else begin
            strb.stepUp = 1'b1;
            strb.load   = 1'b1;
            strb.per    = PER_CORR;
          end
        end else begin
          if (atMin) begin
            leave        = 1'b1;
            strb.setErr2 = 1'b1;
          end else begin
            strb.stepDown = 1'b1;
            strb.load     = 1'b1;
            strb.per      = PER_CORR;
          end
        end
        if (leave) begin
          strb.load = 1'b1;
          if (inCorr && fineEn) begin
            strb.clrMoves = 1'b1;
            strb.per      = PER_CORR;
            nextState     = S_FINE;
          end else begin
            strb.per  = PER_WAIT;
            nextState = S_PLL;
          end
        end
      end
      S_PLL: if (timerDone) begin
        strb.setErr1 = (level != 2'd1);
        nextState    = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/capbank_cal.sv
module capbank_cal
  import cbcal_pkg::*;
#(
  parameter int UNIT       = 4,
  parameter int CODE_W     = 9,
  parameter int CORR_LIMIT = 8,
  parameter int FINE_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sarSel,
  input  logic [1:0]        corrSel,
  input  logic [1:0]        waitSel,
  input  logic              corrEn,
  input  logic              fineEn,
  input  logic [1:0]        level,
  input  logic              manualSel,
  input  logic [CODE_W-1:0] manualCode,
  output logic [CODE_W-1:0] codeOut,
  output logic              busy,
  output logic              errLevel,
  output logic              errSearch
);
  localparam int MOVE_W = $clog2(CORR_LIMIT + 1);

  strobes_t          strb;
  logic [CODE_W-1:0] calCode;
  logic [MOVE_W-1:0] moves;
  logic              timerDone, bitZero, atMax, atMin;

  cbcal_ctrl #(
    .CORR_LIMIT(CORR_LIMIT), .FINE_LIMIT(FINE_LIMIT), .MOVE_W(MOVE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .corrEn(corrEn), .fineEn(fineEn),
    .level(level), .timerDone(timerDone), .bitZero(bitZero), .atMax(atMax),
    .atMin(atMin), .moves(moves), .strb(strb), .busy(busy)
  );

  cbcal_datapath #(
    .UNIT(UNIT), .CODE_W(CODE_W), .MOVE_W(MOVE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .level(level), .sarSel(sarSel),
    .corrSel(corrSel), .waitSel(waitSel), .calCode(calCode), .moves(moves),
    .timerDone(timerDone), .bitZero(bitZero), .atMax(atMax), .atMin(atMin),
    .err1(errLevel), .err2(errSearch)
  );

  assign codeOut = manualSel ? manualCode : calCode;
endmodule

// File: rtl/capbank_cal_checker.sv
module capbank_cal_checker #(
  parameter int CODE_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              errLevel,
  input logic              errSearch,
  input logic              manualSel,
  input logic [CODE_W-1:0] codeOut
);
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_flags_clear_on_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!errLevel && !errSearch));

  assert_flags_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(errLevel) && $stable(errSearch)));

  assert_level_err_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errLevel) |-> $fell(busy));

  assert_search_err_in_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errSearch) |-> busy);

  assert_code_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start && !manualSel) |=> (manualSel || $stable(codeOut)));
endmodule

bind capbank_cal capbank_cal_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .errLevel(errLevel),
  .errSearch(errSearch), .manualSel(manualSel), .codeOut(codeOut)
);

// File: tb/capbank_cal_test.sv
module capbank_cal_test;
  localparam int UNIT = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] sarSel = 2'd0, corrSel = 2'd0, waitSel = 2'd0;
  logic       corrEn = 1'b0, fineEn = 1'b0;
  logic [1:0] level;
  logic       manualSel = 1'b0;
  logic [8:0] manualCode = 9'd0;
  logic [8:0] codeOut;
  logic       busy, errLevel, errSearch;

  int mode = 0, lo = 0, hi = 0, hole = 0;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  capbank_cal #(.UNIT(UNIT)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sarSel(sarSel), .corrSel(corrSel),
    .waitSel(waitSel), .corrEn(corrEn), .fineEn(fineEn), .level(level),
    .manualSel(manualSel), .manualCode(manualCode), .codeOut(codeOut),
    .busy(busy), .errLevel(errLevel), .errSearch(errSearch)
  );

  always #2 clk = ~clk;

  // mode 0 window, 1 always low, 2 always high, 3 window with high hole, 4 window reporting 2 above
  function automatic logic [1:0] lvlFn(int c, int m, int l, int h, int hl);
    if (m == 1) return 2'd0;
    if (m == 2) return 2'd3;
    if (m == 3 && c == hl) return 2'd3;
    if (c < l) return 2'd0;
    if (c <= h) return 2'd1;
    return (m == 4) ? 2'd2 : 2'd3;
  endfunction

  always_comb level = lvlFn(int'(codeOut), mode, lo, hi, hole);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(bit cE, bit fE, int m, int loA, int hiA, int loB, int hiB, int hl,
                       output int c, output bit e1, output bit e2);
    logic [1:0] l;
    c = 0; e1 = 0; e2 = 0;
    for (int i = 8; i >= 0; i--) begin
      int t = c | (1 << i);
      l = lvlFn(t, m, loA, hiA, hl);
      if (!l[1]) c = t;
    end
    for (int p = 0; p < 2; p++) begin
      int lim = (p == 0) ? 8 : 2;
      int n = 0;
      if ((p == 0 && cE) || (p == 1 && fE)) begin
        forever begin
          l = lvlFn(c, m, loB, hiB, hl);
          if (l == 2'd1) break;
          if (n == lim) begin if (p == 0) e2 = 1; break; end
          if (l == 2'd0) begin
            if (c == 511) begin e2 = 1; break; end
            c++;
          end else begin
            if (c == 0) begin e2 = 1; break; end
            c--;
          end
          n++;
        end
      end
    end
    e1 = (lvlFn(c, m, loB, hiB, hl) != 2'd1);
  endtask

  task automatic runCal(string tag, bit cE, bit fE, int sS, int cS, int wS, int m,
                        int loA, int hiA, int hl, bit drift, int loB, int hiB,
                        bit extra, output int dur);
    int expC; bit e1, e2;
    @(negedge clk);
    corrEn = cE; fineEn = fE; sarSel = 2'(sS); corrSel = 2'(cS); waitSel = 2'(wS);
    mode = m; lo = loA; hi = hiA; hole = hl; manualSel = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(errLevel == 0 && errSearch == 0, "R9", "flags cleared on start",
        int'({errLevel, errSearch}), 0);
    dur = 1;
    while (busy && dur < 20000) begin
      start = extra && (dur == 20);
      if (drift && dur == 70) begin lo = loB; hi = hiB; end
      @(negedge clk);
      dur++;
    end
    start = 0;
    model(cE, fE, m, loA, hiA, drift ? loB : loA, drift ? hiB : hiA, hl, expC, e1, e2);
    chk(int'(codeOut) == expC, tag, "final code", int'(codeOut), expC);
    chk(errLevel == e1, tag, "errLevel", int'(errLevel), int'(e1));
    chk(errSearch == e2, tag, "errSearch", int'(errSearch), int'(e2));
  endtask

  task automatic testReset();
    chk(busy == 0, "R1", "busy at reset", int'(busy), 0);
    chk(errLevel == 0 && errSearch == 0, "R1", "flags at reset", int'({errLevel, errSearch}), 0);
    chk(codeOut == 0, "R1", "code at reset", int'(codeOut), 0);
  endtask

  task automatic testTiming();
    int dA, dB, dC, dD;
    runCal("R3", 0, 0, 0, 0, 0, 0, 300, 303, 0, 0, 0, 0, 0, dA);
    runCal("R4", 0, 0, 1, 0, 0, 0, 300, 303, 0, 0, 0, 0, 0, dB);
    chk(dB - dA == 9 * UNIT, "R4", "search step time", dB - dA, 9 * UNIT);
    runCal("R8", 0, 0, 0, 0, 1, 0, 300, 303, 0, 0, 0, 0, 0, dC);
    chk(dC - dA == 20 * UNIT, "R8", "final wait time", dC - dA, 20 * UNIT);
    // R2: a start during the run must not lengthen it
    runCal("R2", 0, 0, 0, 0, 0, 0, 300, 303, 0, 0, 0, 0, 1, dD);
    chk(dD == dA, "R2", "run length with start while busy", dD, dA);
    repeat (5) @(negedge clk);
    chk(busy == 0, "R2", "no restart after run", int'(busy), 0);
  endtask

  task automatic testSearch();
    int d;
    runCal("R3", 0, 0, 0, 0, 0, 0, 17, 17, 0, 0, 0, 0, 0, d);
    runCal("R3", 0, 0, 0, 0, 0, 4, 300, 303, 0, 0, 0, 0, 0, d);
    chk(codeOut == 9'd303, "R3", "level 2 treated as high", int'(codeOut), 303);
  endtask

  task automatic testCorrection();
    int d0, d1;
    runCal("R5", 1, 0, 0, 0, 0, 0, 300, 303, 0, 1, 305, 306, 0, d0);
    chk(codeOut == 9'd305, "R5", "corrected code", int'(codeOut), 305);
    runCal("R5", 1, 0, 0, 0, 0, 3, 270, 280, 256, 0, 0, 0, 0, d0);
    runCal("R5", 1, 0, 0, 1, 0, 3, 270, 280, 256, 0, 0, 0, 0, d1);
    chk(d1 - d0 == 9 * 20 * UNIT, "R5", "correction step time", d1 - d0, 9 * 20 * UNIT);
  endtask

  task automatic testFine();
    int d;
    runCal("R6", 0, 1, 0, 0, 0, 0, 300, 303, 0, 1, 304, 305, 0, d);
    runCal("R6", 0, 1, 0, 0, 0, 0, 300, 303, 0, 1, 310, 311, 0, d);
    chk(codeOut == 9'd305, "R6", "fine limit code", int'(codeOut), 305);
    runCal("R6", 1, 1, 0, 0, 0, 3, 270, 280, 256, 0, 0, 0, 0, d);
  endtask

  task automatic testBounds();
    int d;
    runCal("R7", 1, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, d);
    runCal("R7", 1, 0, 0, 0, 0, 2, 0, 0, 0, 0, 0, 0, 0, d);
    runCal("R8", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, d);
    repeat (10) @(negedge clk);
    chk(errLevel == 1, "R9", "flag held while idle", int'(errLevel), 1);
  endtask

  task automatic testManual();
    logic [8:0] cal;
    cal = codeOut;
    @(negedge clk);
    manualCode = 9'h0A5; manualSel = 1;
    #1;
    chk(codeOut == 9'h0A5, "R10", "manual code", int'(codeOut), 'h0A5);
    manualCode = 9'h1F0;
    #1;
    chk(codeOut == 9'h1F0, "R10", "manual follows", int'(codeOut), 'h1F0);
    @(negedge clk);
    manualSel = 0;
    #1;
    chk(codeOut == cal, "R10", "calibrated code back", int'(codeOut), int'(cal));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testTiming();
    testSearch();
    testCorrection();
    testFine();
    testBounds();
    testManual();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule